// File: doc/BRIEF.md
# Supervisor Trap Entry and Return Unit

This block keeps the supervisor-level trap state of a processor core and does the hardware work of entering a trap and of leaving it with a supervisor return. An exception request comes from the core with a cause code and a trap value. Three level-sensitive interrupt lines come from the platform: external device, timer and software. The block decides in the same cycle whether a trap is taken. It then presents the redirect target at once, and it stacks the status bits, the return pc, the cause and the trap value at the next clock edge.

The current privilege is held in the block and is presented as an output. It is 0 for user and 1 for supervisor. The core reaches the seven trap registers through one small CSR port. The port has a combinational read, and a write that lands at the clock edge. The read returns the value the register holds before that edge. A supervisor return restores the interrupt enable and the privilege from the stacked copies, and redirects to the saved pc.

Top module: `strap_unit`

## Requirements
- R1: After reset, priv_mode is 1 (supervisor), and the status, interrupt-enable, cause, return-pc and trap-value registers read 0. The vector register reads RESET_VEC with bits [1:0] cleared.
- R2: In a cycle that takes a trap, redirect_valid is 1 and redirect_pc equals the vector register. The return-pc register then holds cur_pc. Writes to the vector register (csr_addr 2) store the data with bits [1:0] forced to 0. The return pc is csr_addr 3.
- R3: Taking a trap copies the privilege into status bit 8, copies status bit 1 (global enable) into status bit 5, clears bit 1 and makes priv_mode supervisor. The status register is csr_addr 0.
- R4: When sret_req is accepted, the block redirects to the return-pc register. Status bit 1 takes bit 5, priv_mode takes bit 8, bit 5 becomes 1 and bit 8 becomes 0. With no trap and no return, redirect_valid is 0 and redirect_pc is 0.
- R5: The cause register (csr_addr 4) has its MSB set for interrupts and clear for exceptions. The low bits hold exc_code for an exception, or 9 for external, 1 for software and 5 for timer.
- R6: The trap-value register (csr_addr 5) takes exc_tval on an exception and 0 on an interrupt.
- R7: While status bit 1 is 0, no interrupt is taken and the line stays pending. It is taken in the first cycle in which bit 1 reads 1.
- R8: Interrupt-enable bits 9, 5 and 1 (csr_addr 1) gate the external, timer and software lines. The pending register (csr_addr 6) shows the raw lines at those bit positions. Among enabled pending lines the order is external, then software, then timer.
- R9: An exception is taken whatever status bit 1 holds. It takes priority over an interrupt in the same cycle.
- R10: A CSR write in a cycle that takes a trap or an sret is dropped. Writes to the pending register and to csr_addr 7 change nothing. The status register stores only bits 1, 5 and 8, and the enable register stores only bits 1, 5 and 9.
- R11: A trap in the same cycle as sret_req wins, and the return is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cur_pc | input | XLEN | pc of the instruction at the trap boundary |
| exc_valid | input | 1 | Exception request |
| exc_code | input | CODE_W | Exception cause code |
| exc_tval | input | XLEN | Exception trap value (fault address or instruction word) |
| irq_ext | input | 1 | External device interrupt line |
| irq_tmr | input | 1 | Timer interrupt line |
| irq_sw | input | 1 | Software interrupt line |
| sret_req | input | 1 | Supervisor return strobe |
| csr_we | input | 1 | CSR write enable |
| csr_addr | input | 3 | CSR select: 0 status, 1 enable, 2 vector, 3 return pc, 4 cause, 5 trap value, 6 pending |
| csr_wdata | input | XLEN | CSR write data |
| csr_rdata | output | XLEN | CSR read data for csr_addr |
| redirect_valid | output | 1 | pc redirect this cycle |
| redirect_pc | output | XLEN | Redirect target |
| priv_mode | output | 1 | Current privilege, 0 user, 1 supervisor |

## Verification
The bound checker watches the stacking on every cycle. Trap entry must clear the global enable, move its old value into the previous-enable bit and raise the privilege. A return must restore both, and no interrupt may be taken while the global enable is clear. The checker also checks the redirect target on every trap, and that an exception, even one arriving with a return, ends with an exception cause and supervisor privilege. Other behaviours only show up in the bench's scenarios. These are an interrupt held pending and then taken after a software write sets the enable, the priority order among lines, dropped writes in a trap cycle and read-only pending bits.

// File: rtl/strap_pkg.sv
package strap_pkg;

  typedef enum logic {
    PRIV_USER  = 1'b0,
    PRIV_SUPER = 1'b1
  } priv_e;

  typedef enum logic [2:0] {
    CSR_STATUS = 3'd0,
    CSR_IEN    = 3'd1,
    CSR_TVEC   = 3'd2,
    CSR_EPC    = 3'd3,
    CSR_CAUSE  = 3'd4,
    CSR_TVAL   = 3'd5,
    CSR_IPEND  = 3'd6,
    CSR_NONE   = 3'd7
  } csr_sel_e;

  // status register bit positions, decoded by software
  localparam int unsigned ST_GIE_POS  = 1;
  localparam int unsigned ST_PGIE_POS = 5;
  localparam int unsigned ST_PPRV_POS = 8;

  // interrupt sources, index into 3-bit line vectors
  localparam int unsigned NSRC    = 3;
  localparam int unsigned SRC_SW  = 0;
  localparam int unsigned SRC_TMR = 1;
  localparam int unsigned SRC_EXT = 2;

  typedef struct packed {
    logic pprv;   // privilege before the trap
    logic pgie;   // global enable before the trap
    logic gie;    // global interrupt enable
  } stat_t;

  // bit position of a source in the enable/pending words; also its cause code
  function automatic int unsigned src_pos(input int unsigned s);
    return 1 + 4 * s;
  endfunction

endpackage

// File: rtl/strap_irq_arb.sv
module strap_irq_arb
  import strap_pkg::*;
(
  input  logic [NSRC-1:0] lines,
  input  logic [NSRC-1:0] ien,
  input  logic            gie,
  output logic            irq_fire,
  output logic [3:0]      irq_code
);

  logic [NSRC-1:0] active;

  assign active   = lines & ien;
  assign irq_fire = gie & (|active);

  // lowest priority first; the last match wins
  always_comb begin
    irq_code = 4'(src_pos(SRC_TMR));
    if (active[SRC_SW])  irq_code = 4'(src_pos(SRC_SW));
    if (active[SRC_EXT]) irq_code = 4'(src_pos(SRC_EXT));
  end

endmodule

// File: rtl/strap_status.sv
module strap_status
  import strap_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  trap_fire,
  input  logic  sret_fire,
  input  logic  wr_status,
  input  stat_t wr_val,
  output stat_t stat_q,
  output priv_e priv_q
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stat_q <= '0;
      priv_q <= PRIV_SUPER;
    end else if (trap_fire) begin
      stat_q.pprv <= logic'(priv_q);
      stat_q.pgie <= stat_q.gie;
      stat_q.gie  <= 1'b0;
      priv_q      <= PRIV_SUPER;
    end else if (sret_fire) begin
      stat_q.gie  <= stat_q.pgie;
      priv_q      <= priv_e'(stat_q.pprv);
      stat_q.pgie <= 1'b1;
      stat_q.pprv <= 1'b0;
    end else if (wr_status) begin
      stat_q <= wr_val;
    end
  end

endmodule

// File: rtl/strap_regs.sv
module strap_regs
  import strap_pkg::*;
#(
  parameter int unsigned XLEN      = 32,
  parameter int unsigned CODE_W    = 5,
  parameter logic [XLEN-1:0] RESET_VEC = XLEN'(32'h0000_0100)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              trap_fire,
  input  logic              trap_is_irq,
  input  logic [CODE_W-1:0] trap_code,
  input  logic [XLEN-1:0]   trap_tval,
  input  logic [XLEN-1:0]   cur_pc,
  input  logic              wr_en,
  input  csr_sel_e          wr_sel,
  input  logic [XLEN-1:0]   wr_data,
  output logic [XLEN-1:0]   epc_q,
  output logic [XLEN-1:0]   cause_q,
  output logic [XLEN-1:0]   tval_q,
  output logic [XLEN-1:0]   tvec_q,
  output logic [NSRC-1:0]   ien_q
);

  function automatic logic [XLEN-1:0] cause_word(input logic is_irq,
                                                 input logic [CODE_W-1:0] code);
    logic [XLEN-1:0] w;
    w = '0;
    w[CODE_W-1:0] = code;
    w[XLEN-1] = is_irq;
    return w;
  endfunction

  function automatic logic [XLEN-1:0] vec_align(input logic [XLEN-1:0] v);
    return {v[XLEN-1:2], 2'b00};
  endfunction

  function automatic logic [NSRC-1:0] ien_pick(input logic [XLEN-1:0] d);
    logic [NSRC-1:0] e;
    for (int unsigned s = 0; s < NSRC; s++) e[s] = d[src_pos(s)];
    return e;
  endfunction

  // registers the trap also writes: trap first, then software
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      epc_q   <= '0;
      cause_q <= '0;
      tval_q  <= '0;
    end else if (trap_fire) begin
      epc_q   <= cur_pc;
      cause_q <= cause_word(trap_is_irq, trap_code);
      tval_q  <= trap_tval;
    end else if (wr_en) begin
      case (wr_sel)
        CSR_EPC:   epc_q   <= wr_data;
        CSR_CAUSE: cause_q <= wr_data;
        CSR_TVAL:  tval_q  <= wr_data;
        default: ;
      endcase
    end
  end

  // software-only registers
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tvec_q <= vec_align(RESET_VEC);
      ien_q  <= '0;
    end else if (wr_en) begin
      if (wr_sel == CSR_TVEC) tvec_q <= vec_align(wr_data);
      if (wr_sel == CSR_IEN)  ien_q  <= ien_pick(wr_data);
    end
  end

endmodule

// File: rtl/strap_unit.sv
module strap_unit
  import strap_pkg::*;
#(
  parameter int unsigned XLEN      = 32,
  parameter int unsigned CODE_W    = 5,
  parameter logic [XLEN-1:0] RESET_VEC = XLEN'(32'h0000_0100)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [XLEN-1:0]   cur_pc,
  input  logic              exc_valid,
  input  logic [CODE_W-1:0] exc_code,
  input  logic [XLEN-1:0]   exc_tval,
  input  logic              irq_ext,
  input  logic              irq_tmr,
  input  logic              irq_sw,
  input  logic              sret_req,
  input  logic              csr_we,
  input  logic [2:0]        csr_addr,
  input  logic [XLEN-1:0]   csr_wdata,
  output logic [XLEN-1:0]   csr_rdata,
  output logic              redirect_valid,
  output logic [XLEN-1:0]   redirect_pc,
  output logic              priv_mode
);

  localparam int unsigned IRQ_PAD = CODE_W - 4;

  // named internal events, observed by the bound checker
  logic              trap_fire;
  logic              irq_fire;
  logic              sret_fire;
  logic              wr_ok;
  logic              gie_w;
  logic              pgie_w;
  logic              pprv_w;
  logic              cause_msb_w;

  logic [NSRC-1:0]   lines;
  logic [3:0]        irq_code;
  logic              trap_is_irq;
  logic [CODE_W-1:0] trap_code;
  logic [XLEN-1:0]   trap_tval;
  csr_sel_e          sel;
  stat_t             stat_q;
  stat_t             wr_stat;
  priv_e             priv_q;
  logic [XLEN-1:0]   epc_q, cause_q, tval_q, tvec_q;
  logic [NSRC-1:0]   ien_q;

  function automatic logic [XLEN-1:0] status_word(input stat_t s);
    logic [XLEN-1:0] w;
    w = '0;
    w[ST_GIE_POS]  = s.gie;
    w[ST_PGIE_POS] = s.pgie;
    w[ST_PPRV_POS] = s.pprv;
    return w;
  endfunction

  function automatic stat_t status_pick(input logic [XLEN-1:0] d);
    stat_t s;
    s.gie  = d[ST_GIE_POS];
    s.pgie = d[ST_PGIE_POS];
    s.pprv = d[ST_PPRV_POS];
    return s;
  endfunction

  // place per-source bits into a word at their fixed positions
  function automatic logic [XLEN-1:0] src_word(input logic [NSRC-1:0] v);
    logic [XLEN-1:0] w;
    w = '0;
    for (int unsigned s = 0; s < NSRC; s++) w[src_pos(s)] = v[s];
    return w;
  endfunction

  assign lines[SRC_SW]  = irq_sw;
  assign lines[SRC_TMR] = irq_tmr;
  assign lines[SRC_EXT] = irq_ext;

  strap_irq_arb u_arb (
    .lines    (lines),
    .ien      (ien_q),
    .gie      (stat_q.gie),
    .irq_fire (irq_fire),
    .irq_code (irq_code)
  );

  // exceptions are taken unconditionally and outrank interrupts
  assign trap_fire   = exc_valid | irq_fire;
  assign trap_is_irq = ~exc_valid;
  assign trap_code   = exc_valid ? exc_code : {{IRQ_PAD{1'b0}}, irq_code};
  assign trap_tval   = exc_valid ? exc_tval : '0;
  assign sret_fire   = sret_req & ~trap_fire;
  assign wr_ok       = csr_we & ~trap_fire & ~sret_fire;
  assign sel         = csr_sel_e'(csr_addr);
  assign wr_stat     = status_pick(csr_wdata);

  strap_status u_status (
    .clk       (clk),
    .rst_n     (rst_n),
    .trap_fire (trap_fire),
    .sret_fire (sret_fire),
    .wr_status (wr_ok && (sel == CSR_STATUS)),
    .wr_val    (wr_stat),
    .stat_q    (stat_q),
    .priv_q    (priv_q)
  );

  strap_regs #(
    .XLEN      (XLEN),
    .CODE_W    (CODE_W),
    .RESET_VEC (RESET_VEC)
  ) u_regs (
    .clk         (clk),
    .rst_n       (rst_n),
    .trap_fire   (trap_fire),
    .trap_is_irq (trap_is_irq),
    .trap_code   (trap_code),
    .trap_tval   (trap_tval),
    .cur_pc      (cur_pc),
    .wr_en       (wr_ok),
    .wr_sel      (sel),
    .wr_data     (csr_wdata),
    .epc_q       (epc_q),
    .cause_q     (cause_q),
    .tval_q      (tval_q),
    .tvec_q      (tvec_q),
    .ien_q       (ien_q)
  );

  always_comb begin
    redirect_valid = trap_fire | sret_fire;
    if (trap_fire)      redirect_pc = tvec_q;
    else if (sret_fire) redirect_pc = epc_q;
    else                redirect_pc = '0;
  end

  always_comb begin
    case (sel)
      CSR_STATUS: csr_rdata = status_word(stat_q);
      CSR_IEN:    csr_rdata = src_word(ien_q);
      CSR_TVEC:   csr_rdata = tvec_q;
      CSR_EPC:    csr_rdata = epc_q;
      CSR_CAUSE:  csr_rdata = cause_q;
      CSR_TVAL:   csr_rdata = tval_q;
      CSR_IPEND:  csr_rdata = src_word(lines);
      default:    csr_rdata = '0;
    endcase
  end

  assign priv_mode   = logic'(priv_q);
  assign gie_w       = stat_q.gie;
  assign pgie_w      = stat_q.pgie;
  assign pprv_w      = stat_q.pprv;
  assign cause_msb_w = cause_q[XLEN-1];

endmodule

// File: rtl/strap_chk.sv
module strap_chk #(
  parameter int unsigned XLEN = 32
) (
  input logic            clk,
  input logic            rst_n,
  input logic            trap_fire,
  input logic            irq_fire,
  input logic            sret_fire,
  input logic            sret_req,
  input logic            exc_valid,
  input logic            gie_w,
  input logic            pgie_w,
  input logic            pprv_w,
  input logic            priv_mode,
  input logic            cause_msb_w,
  input logic            redirect_valid,
  input logic [XLEN-1:0] redirect_pc,
  input logic [XLEN-1:0] tvec_q
);

  // R2: trap redirects to the vector
  a_r2_trap_redirect: assert property (@(posedge clk) disable iff (!rst_n)
    trap_fire |-> (redirect_valid && redirect_pc == tvec_q));

  // R3: entry clears the enable and raises the privilege
  a_r3_entry_masks: assert property (@(posedge clk) disable iff (!rst_n)
    trap_fire |=> (!gie_w && priv_mode));

  // R3: entry stacks enable and privilege
  a_r3_entry_stacks: assert property (@(posedge clk) disable iff (!rst_n)
    trap_fire |=> (pgie_w == $past(gie_w) && pprv_w == $past(priv_mode)));

  // R4: return restores enable and privilege
  a_r4_sret_restore: assert property (@(posedge clk) disable iff (!rst_n)
    sret_fire |=> (gie_w == $past(pgie_w) && priv_mode == $past(pprv_w)
                   && pgie_w && !pprv_w));

  // R7: no interrupt while the enable is clear
  a_r7_masked_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !gie_w |-> !irq_fire);

  // R9: an exception always lands with an exception cause
  a_r9_exc_wins: assert property (@(posedge clk) disable iff (!rst_n)
    exc_valid |=> (!cause_msb_w && priv_mode && !gie_w));

  // R11: a trap beside a return leaves supervisor state
  a_r11_trap_over_sret: assert property (@(posedge clk) disable iff (!rst_n)
    (sret_req && exc_valid) |=> (priv_mode && !gie_w && !cause_msb_w));

endmodule

bind strap_unit strap_chk #(.XLEN(XLEN)) u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .trap_fire      (trap_fire),
  .irq_fire       (irq_fire),
  .sret_fire      (sret_fire),
  .sret_req       (sret_req),
  .exc_valid      (exc_valid),
  .gie_w          (gie_w),
  .pgie_w         (pgie_w),
  .pprv_w         (pprv_w),
  .priv_mode      (priv_mode),
  .cause_msb_w    (cause_msb_w),
  .redirect_valid (redirect_valid),
  .redirect_pc    (redirect_pc),
  .tvec_q         (tvec_q)
);

// File: tb/test_strap_unit.sv
`timescale 1ns/1ps
module test_strap_unit;

  localparam logic [31:0] RVEC = 32'h0000_0100;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] cur_pc = '0;
  logic        exc_valid = 1'b0;
  logic [4:0]  exc_code = '0;
  logic [31:0] exc_tval = '0;
  logic        irq_ext = 1'b0, irq_tmr = 1'b0, irq_sw = 1'b0;
  logic        sret_req = 1'b0;
  logic        csr_we = 1'b0;
  logic [2:0]  csr_addr = '0;
  logic [31:0] csr_wdata = '0;
  logic [31:0] csr_rdata;
  logic        redirect_valid;
  logic [31:0] redirect_pc;
  logic        priv_mode;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  // reference state
  bit          m_gie, m_pgie, m_pprv, m_priv;
  logic [31:0] m_epc, m_cause, m_tval, m_tvec;
  bit          m_ie_x, m_ie_t, m_ie_s;

  always #10 clk = ~clk;

  strap_unit i_strap_unit (
    .clk(clk), .rst_n(rst_n), .cur_pc(cur_pc), .exc_valid(exc_valid),
    .exc_code(exc_code), .exc_tval(exc_tval), .irq_ext(irq_ext),
    .irq_tmr(irq_tmr), .irq_sw(irq_sw), .sret_req(sret_req),
    .csr_we(csr_we), .csr_addr(csr_addr), .csr_wdata(csr_wdata),
    .csr_rdata(csr_rdata), .redirect_valid(redirect_valid),
    .redirect_pc(redirect_pc), .priv_mode(priv_mode)
  );

  task automatic check(input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  function automatic logic [31:0] model_read(input logic [2:0] a, input bit lx,
                                             input bit lt, input bit ls);
    case (a)
      3'd0: return (32'(m_gie) << 1) | (32'(m_pgie) << 5) | (32'(m_pprv) << 8);
      3'd1: return (32'(m_ie_x) << 9) | (32'(m_ie_t) << 5) | (32'(m_ie_s) << 1);
      3'd2: return m_tvec;
      3'd3: return m_epc;
      3'd4: return m_cause;
      3'd5: return m_tval;
      3'd6: return (32'(lx) << 9) | (32'(lt) << 5) | (32'(ls) << 1);
      default: return 32'h0;
    endcase
  endfunction

  function automatic logic [31:0] model_irq_code(input bit lx, input bit ls);
    if (lx && m_ie_x) return 32'd9;
    if (ls && m_ie_s) return 32'd1;
    return 32'd5;
  endfunction

  task automatic model_reset();
    m_gie = 0; m_pgie = 0; m_pprv = 0; m_priv = 1;
    m_epc = '0; m_cause = '0; m_tval = '0; m_tvec = RVEC & ~32'h3;
    m_ie_x = 0; m_ie_t = 0; m_ie_s = 0;
  endtask

  task automatic step(input string tag, input bit ev, input logic [4:0] ec,
                      input logic [31:0] tv, input bit lx, input bit lt,
                      input bit ls, input bit sr, input bit we,
                      input logic [2:0] ad, input logic [31:0] wd,
                      input logic [31:0] pc);
    bit irq, trap, srt;
    @(negedge clk);
    exc_valid = ev; exc_code = ec; exc_tval = tv;
    irq_ext = lx; irq_tmr = lt; irq_sw = ls;
    sret_req = sr; csr_we = we; csr_addr = ad; csr_wdata = wd; cur_pc = pc;
    #1;
    irq  = m_gie && ((lx && m_ie_x) || (lt && m_ie_t) || (ls && m_ie_s));
    trap = ev || irq;
    srt  = sr && !trap;
    check(tag, "redirect_valid", 32'(redirect_valid), 32'(trap || srt));
    check(tag, "redirect_pc", redirect_pc, trap ? m_tvec : (srt ? m_epc : 32'h0));
    check(tag, "priv_mode", 32'(priv_mode), 32'(m_priv));
    check(tag, "csr_rdata", csr_rdata, model_read(ad, lx, lt, ls));
    if (trap) begin
      m_epc  = pc;
      m_cause = ev ? 32'(ec) : (32'h8000_0000 | model_irq_code(lx, ls));
      m_tval = ev ? tv : 32'h0;
      m_pprv = m_priv; m_pgie = m_gie; m_gie = 0; m_priv = 1;
    end else if (srt) begin
      m_gie = m_pgie; m_priv = m_pprv; m_pgie = 1; m_pprv = 0;
    end else if (we) begin
      case (ad)
        3'd0: begin m_gie = wd[1]; m_pgie = wd[5]; m_pprv = wd[8]; end
        3'd1: begin m_ie_x = wd[9]; m_ie_t = wd[5]; m_ie_s = wd[1]; end
        3'd2: m_tvec = wd & ~32'h3;
        3'd3: m_epc = wd;
        3'd4: m_cause = wd;
        3'd5: m_tval = wd;
        default: ;
      endcase
    end
  endtask

  // shorthand for a plain read or write cycle with the lines held
  task automatic rw(input string tag, input bit lx, input bit lt, input bit ls,
                    input bit we, input logic [2:0] ad, input logic [31:0] wd);
    step(tag, 0, 5'd0, 32'h0, lx, lt, ls, 0, we, ad, wd, 32'h0);
  endtask

  initial begin
    model_reset();
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;

    // R1: reset contents
    for (int a = 0; a < 8; a++) rw("R1", 0, 0, 0, 0, 3'(a), 32'h0);

    // R2: vector write drops low bits, exception redirects there
    rw("R2", 0, 0, 0, 1, 3'd2, 32'h0000_2003);
    rw("R2", 0, 0, 0, 0, 3'd2, 32'h0);
    step("R2", 1, 5'd2, 32'h0BAD_0013, 0, 0, 0, 0, 0, 3'd3, 32'h0, 32'h0000_0400);
    rw("R2", 0, 0, 0, 0, 3'd3, 32'h0);
    rw("R6", 0, 0, 0, 0, 3'd5, 32'h0);
    rw("R5", 0, 0, 0, 0, 3'd4, 32'h0);

    // R4: return to user via stacked previous privilege 0
    rw("R4", 0, 0, 0, 1, 3'd0, 32'h0000_0020);
    step("R4", 0, 5'd0, 32'h0, 0, 0, 0, 1, 0, 3'd0, 32'h0, 32'h0);
    rw("R4", 0, 0, 0, 0, 3'd0, 32'h0);
    // user ecall: previous privilege 0 stacked, cause 8
    step("R3", 1, 5'd8, 32'h0, 0, 0, 0, 0, 0, 3'd0, 32'h0, 32'h0000_0800);
    rw("R3", 0, 0, 0, 0, 3'd0, 32'h0);
    rw("R5", 0, 0, 0, 0, 3'd4, 32'h0);

    // R7: timer pending while the enable is clear
    rw("R8", 0, 0, 0, 1, 3'd1, 32'h0000_0222);
    rw("R7", 0, 1, 0, 0, 3'd6, 32'h0);
    rw("R7", 0, 1, 0, 0, 3'd4, 32'h0);
    rw("R7", 0, 1, 0, 1, 3'd0, 32'h0000_0002);
    rw("R7", 0, 1, 0, 0, 3'd4, 32'h0);
    rw("R5", 0, 1, 0, 0, 3'd4, 32'h0);
    rw("R6", 0, 1, 0, 0, 3'd5, 32'h0);

    // R9: exception and interrupt in the same cycle
    rw("R9", 0, 1, 0, 1, 3'd0, 32'h0000_0002);
    step("R9", 1, 5'd13, 32'h0000_7FF0, 0, 1, 0, 0, 0, 3'd0, 32'h0, 32'h0000_1234);
    rw("R9", 0, 1, 0, 0, 3'd4, 32'h0);

    // R11: exception beside a return
    step("R11", 1, 5'd2, 32'hDEAD_BEEF, 0, 0, 0, 1, 0, 3'd0, 32'h0, 32'h0000_5000);
    rw("R11", 0, 0, 0, 0, 3'd0, 32'h0);

    // R10: write dropped on a trap cycle, pending and slot 7 read-only
    step("R10", 1, 5'd4, 32'h0, 0, 0, 0, 0, 1, 3'd2, 32'hFFFF_0000, 32'h0000_6000);
    rw("R10", 0, 0, 0, 0, 3'd2, 32'h0);
    rw("R10", 1, 0, 1, 1, 3'd6, 32'hFFFF_FFFF);
    rw("R10", 1, 0, 1, 0, 3'd6, 32'h0);
    rw("R10", 0, 0, 0, 1, 3'd7, 32'hFFFF_FFFF);
    rw("R10", 0, 0, 0, 1, 3'd0, 32'hFFFF_FEDD);
    rw("R10", 0, 0, 0, 0, 3'd0, 32'h0);

    // R8: masked sources, then priority external > software > timer
    rw("R8", 0, 0, 0, 1, 3'd1, 32'h0000_0020);
    rw("R8", 1, 0, 1, 1, 3'd0, 32'h0000_0002);
    rw("R8", 1, 0, 1, 0, 3'd4, 32'h0);
    rw("R8", 1, 1, 1, 1, 3'd1, 32'hFFFF_FFFF);
    rw("R8", 1, 1, 1, 0, 3'd4, 32'h0);
    rw("R8", 0, 1, 1, 1, 3'd0, 32'h0000_0002);
    rw("R8", 0, 1, 1, 0, 3'd4, 32'h0);

    // constrained random traffic
    void'($urandom(32'd1234));
    begin
      bit lx = 0, lt = 0, ls = 0;
      for (int i = 0; i < 4000; i++) begin
        bit ev, sr, we;
        logic [2:0] ad;
        if ($urandom_range(3) == 0) lx = 1'($urandom);
        if ($urandom_range(3) == 0) lt = 1'($urandom);
        if ($urandom_range(3) == 0) ls = 1'($urandom);
        ev = ($urandom_range(7) == 0);
        sr = ($urandom_range(7) == 0);
        we = ($urandom_range(3) == 0);
        ad = 3'($urandom);
        step("R3", ev, 5'($urandom_range(15)), $urandom, lx, lt, ls, sr, we, ad,
             $urandom, {$urandom} & ~32'h3);
      end
    end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL R1 watchdog: actual 0 expected 1 (run did not end)");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

endmodule